// File: doc/BRIEF.md
# Processor Data Port to Wishbone Master Bridge

This block sits between a processor's data-memory port and a single Wishbone bus. The processor side has two request channels, one for loads and one for stores. Each channel has an enable, a 32-bit byte address and a 2-bit size code, and the store channel also carries 32 bits of data. The processor gets back a ready flag and right-justified load data. The bus side drives cycle and strobe flags, a write flag, a word address, byte-lane selects and lane-steered write data. It takes an acknowledge and read data from the slave.

The processor holds a request until it sees ready. The bridge registers the request when it arrives from idle, and the bus signals come from those registers. When a load and a store are asked for in the same cycle, the bridge runs the store first and then the load, as two back-to-back bus transactions. Ready stays low until the second one is acknowledged.

Size codes: 00 is byte, 01 is halfword, 10 is word, and 11 is handled as a word.

Top module: `core_wb_bridge`

## Requirements
- R1: After reset, and whenever no transaction is in progress, wbCyc, wbStb and wbWe are 0. While idle with neither enable set, coreReady is 1.
- R2: A load request seen while idle raises wbCyc and wbStb with wbWe=0 on the next clock edge.
- R3: A store request raises wbCyc and wbStb with wbWe=1. Write data is shifted left by 8 times the lane offset, so the selected lanes carry the low-order bytes of wrData.
- R4: wbAdr equals bits [31:2] of the byte address of the access in progress.
- R5: wbSel uses little-endian lanes. A byte at offset n sets only bit n. A halfword sets 0011 when address bit 1 is 0 and 1100 when it is 1, and address bit 0 is ignored. A word, or size code 11, sets 1111.
- R6: For a load-only or store-only request, coreReady is 0 while the transaction waits and equals wbAck once it is acknowledged. With acknowledge latency L, ready is seen in cycle 2+L after the request is presented.
- R7: Load data is taken from the selected lanes, shifted down to bit 0 and zero-extended to 32 bits.
- R8: When both enables are set together, the store transaction runs first and coreReady stays 0 on its acknowledge. The load follows, and its acknowledge gives coreReady=1 with the load data. With latency L, ready is seen in cycle 4+2L.
- R9: wbAdr, wbSel, wbDatO and wbWe stay stable from the cycle wbStb rises until wbAck is sampled. wbCyc and wbStb are 0 in the cycle after the final acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Load request |
| rdAddr | input | 32 | Load byte address |
| rdSize | input | 2 | Load size code |
| wrEn | input | 1 | Store request |
| wrAddr | input | 32 | Store byte address |
| wrSize | input | 2 | Store size code |
| wrData | input | 32 | Store data, right-justified |
| coreReady | output | 1 | Access complete, or idle |
| coreRdData | output | 32 | Load data, zero-extended |
| wbCyc | output | 1 | Bus cycle active |
| wbStb | output | 1 | Bus strobe |
| wbWe | output | 1 | Bus write flag |
| wbAdr | output | 30 | Bus word address |
| wbSel | output | 4 | Byte-lane selects |
| wbDatO | output | 32 | Bus write data |
| wbAck | input | 1 | Slave acknowledge |
| wbDatI | input | 32 | Slave read data |

## Verification
The assertions assume a well-behaved environment. The processor keeps its enables and addresses steady until it sees ready, and the slave raises wbAck only while wbStb is high, for exactly one cycle per transaction. The bench follows both rules. Each processor task drives a request on a falling edge and holds it until ready is seen. The slave model returns a single registered acknowledge after a programmed latency, then drops it for at least one cycle before it can acknowledge again.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int LANES     = DATA_W / 8;
  localparam int OFF_W     = $clog2(LANES);
  localparam int BUS_ADR_W = ADDR_W - OFF_W;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // register the request channels
    logic busWrite;  // bus currently carries the store transaction
  } ctrlStrobes_t;

  // lane offset after alignment to the access size
  function automatic logic [OFF_W-1:0] laneOffset(input logic [OFF_W-1:0] lowAddr,
                                                  input logic [1:0] size);
    case (size)
      2'b00:   laneOffset = lowAddr;
      2'b01:   laneOffset = {lowAddr[OFF_W-1:1], 1'b0};
      default: laneOffset = '0;
    endcase
  endfunction

  // lanes covered by an access of this size at offset zero
  function automatic logic [LANES-1:0] laneMask(input logic [1:0] size);
    case (size)
      2'b00:   laneMask = LANES'(1);
      2'b01:   laneMask = LANES'(3);
      default: laneMask = '1;
    endcase
  endfunction
endpackage

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
  import cwb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rdEn,
  input  logic         wrEn,
  input  logic         wbAck,
  output logic         wbCyc,
  output logic         wbStb,
  output logic         wbWe,
  output logic         coreReady,
  output ctrlStrobes_t strobes
);
  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_READ} phase_e;

  phase_e phase, phaseNext;
  logic   readPending, readPendingNext;

  always_comb begin
    phaseNext       = phase;
    readPendingNext = readPending;
    case (phase)
      S_IDLE: begin
        if (wrEn) begin
          phaseNext       = S_WRITE;
          readPendingNext = rdEn;
        end else if (rdEn) begin
          phaseNext       = S_READ;
          readPendingNext = 1'b0;
        end
      end
      S_WRITE: begin
        if (wbAck) begin
          phaseNext       = readPending ? S_READ : S_IDLE;
          readPendingNext = 1'b0;
        end
      end
      S_READ: begin
        if (wbAck) phaseNext = S_IDLE;
      end
      default: phaseNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= S_IDLE;
      readPending <= 1'b0;
    end else begin
      phase       <= phaseNext;
      readPending <= readPendingNext;
    end
  end

  assign wbCyc = (phase != S_IDLE);
  assign wbStb = (phase != S_IDLE);
  assign wbWe  = (phase == S_WRITE);

  always_comb begin
    case (phase)
      S_IDLE:  coreReady = !rdEn && !wrEn;
      S_WRITE: coreReady = wbAck && !readPending;
      S_READ:  coreReady = wbAck;
      default: coreReady = 1'b0;
    endcase
  end

  assign strobes.capture  = (phase == S_IDLE) && (rdEn || wrEn);
  assign strobes.busWrite = (phase == S_WRITE);
endmodule

// File: rtl/cwb_datapath.sv
module cwb_datapath
  import cwb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [1:0]           rdSize,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [1:0]           wrSize,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    wbDatI,
  output logic [BUS_ADR_W-1:0] wbAdr,
  output logic [LANES-1:0]     wbSel,
  output logic [DATA_W-1:0]    wbDatO,
  output logic [DATA_W-1:0]    coreRdData
);
  logic [ADDR_W-1:0] rdAdrQ, wrAdrQ;
  logic [1:0]        rdSizeQ, wrSizeQ;
  logic [DATA_W-1:0] wrDataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAdrQ  <= '0;
      wrAdrQ  <= '0;
      rdSizeQ <= '0;
      wrSizeQ <= '0;
      wrDataQ <= '0;
    end else if (strobes.capture) begin
      rdAdrQ  <= rdAddr;
      wrAdrQ  <= wrAddr;
      rdSizeQ <= rdSize;
      wrSizeQ <= wrSize;
      wrDataQ <= wrData;
    end
  end

  logic [OFF_W-1:0]  wrOff, rdOff;
  logic [LANES-1:0]  wrSel, rdSel, rdKeep;
  logic [DATA_W-1:0] wrLanes, rdShifted;

  assign wrOff   = laneOffset(wrAdrQ[OFF_W-1:0], wrSizeQ);
  assign rdOff   = laneOffset(rdAdrQ[OFF_W-1:0], rdSizeQ);
  assign wrSel   = laneMask(wrSizeQ) << wrOff;
  assign rdKeep  = laneMask(rdSizeQ);
  assign rdSel   = rdKeep << rdOff;
  assign wrLanes = wrDataQ << {wrOff, 3'b000};
  assign rdShifted = wbDatI >> {rdOff, 3'b000};

  assign wbAdr  = strobes.busWrite ? wrAdrQ[ADDR_W-1:OFF_W] : rdAdrQ[ADDR_W-1:OFF_W];
  assign wbSel  = strobes.busWrite ? wrSel : rdSel;
  assign wbDatO = strobes.busWrite ? wrLanes : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_rdLane
    assign coreRdData[g*8 +: 8] = rdKeep[g] ? rdShifted[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/core_wb_bridge.sv
module core_wb_bridge
  import cwb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [1:0]           rdSize,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [1:0]           wrSize,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 coreReady,
  output logic [DATA_W-1:0]    coreRdData,
  output logic                 wbCyc,
  output logic                 wbStb,
  output logic                 wbWe,
  output logic [BUS_ADR_W-1:0] wbAdr,
  output logic [LANES-1:0]     wbSel,
  output logic [DATA_W-1:0]    wbDatO,
  input  logic                 wbAck,
  input  logic [DATA_W-1:0]    wbDatI
);
  ctrlStrobes_t strobes;

  cwb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdEn      (rdEn),
    .wrEn      (wrEn),
    .wbAck     (wbAck),
    .wbCyc     (wbCyc),
    .wbStb     (wbStb),
    .wbWe      (wbWe),
    .coreReady (coreReady),
    .strobes   (strobes)
  );

  cwb_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rdAddr     (rdAddr),
    .rdSize     (rdSize),
    .wrAddr     (wrAddr),
    .wrSize     (wrSize),
    .wrData     (wrData),
    .wbDatI     (wbDatI),
    .wbAdr      (wbAdr),
    .wbSel      (wbSel),
    .wbDatO     (wbDatO),
    .coreRdData (coreRdData)
  );
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker
  import cwb_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdEn,
  input logic                 wrEn,
  input logic                 coreReady,
  input logic                 wbCyc,
  input logic                 wbStb,
  input logic                 wbWe,
  input logic [BUS_ADR_W-1:0] wbAdr,
  input logic [LANES-1:0]     wbSel,
  input logic [DATA_W-1:0]    wbDatO,
  input logic                 wbAck
);
  // R1: no strobe or write flag outside a bus cycle
  a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !wbCyc |-> (!wbStb && !wbWe));

  // R1: idle with no request reports ready
  a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rstN)
    (!wbCyc && !rdEn && !wrEn) |-> coreReady);

  // R5: an active strobe always selects at least one lane
  a_r5_sel_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    wbStb |-> (wbSel != '0));

  // R6: during a bus cycle ready only comes with an acknowledge
  a_r6_ready_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && coreReady) |-> wbAck);

  // R8: an acknowledged store that does not complete is followed by the load
  a_r8_read_follows: assert property (@(posedge clk) disable iff (!rstN)
    (wbAck && wbWe && !coreReady) |=> (wbStb && !wbWe));

  // R9: bus fields hold while waiting for the acknowledge
  a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rstN)
    (wbStb && !wbAck) |=> ($stable(wbAdr) && $stable(wbSel) &&
                           $stable(wbDatO) && $stable(wbWe) && wbStb));

  // R9: the cycle ends right after the final acknowledge
  a_r9_cycle_drops: assert property (@(posedge clk) disable iff (!rstN)
    (wbAck && coreReady) |=> (!wbCyc && !wbStb));
endmodule

bind core_wb_bridge cwb_checker u_cwb_checker (.*);

// File: tb/tb_core_wb_bridge.sv
module tb_core_wb_bridge;
  logic        clk = 1'b0;
  logic        rstN;
  logic        rdEn, wrEn;
  logic [31:0] rdAddr, wrAddr, wrData;
  logic [1:0]  rdSize, wrSize;
  logic        coreReady;
  logic [31:0] coreRdData;
  logic        wbCyc, wbStb, wbWe;
  logic [29:0] wbAdr;
  logic [3:0]  wbSel;
  logic [31:0] wbDatO;
  logic        wbAck;
  logic [31:0] wbDatI;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  core_wb_bridge dut (
    .clk(clk), .rstN(rstN),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdSize(rdSize),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrSize(wrSize), .wrData(wrData),
    .coreReady(coreReady), .coreRdData(coreRdData),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAdr(wbAdr),
    .wbSel(wbSel), .wbDatO(wbDatO), .wbAck(wbAck), .wbDatI(wbDatI)
  );

  // slave model: one registered acknowledge after slvLat waiting edges
  int          slvLat = 0;
  int          slvCnt;
  int          txnCount;
  logic        txnWe  [8];
  logic [29:0] txnAdr [8];
  logic [3:0]  txnSel [8];
  logic [31:0] txnDat [8];

  assign wbDatI = 32'hA1B2C3D4;

  always @(posedge clk) begin
    if (!rstN) begin
      wbAck    <= 1'b0;
      slvCnt   <= 0;
      txnCount <= 0;
    end else if (wbAck) begin
      wbAck  <= 1'b0;
      slvCnt <= 0;
    end else if (wbStb) begin
      if (slvCnt == slvLat) begin
        wbAck <= 1'b1;
        txnWe [txnCount % 8] <= wbWe;
        txnAdr[txnCount % 8] <= wbAdr;
        txnSel[txnCount % 8] <= wbSel;
        txnDat[txnCount % 8] <= wbDatO;
        txnCount <= txnCount + 1;
      end else begin
        slvCnt <= slvCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] laneBits(input logic [3:0] sel);
    for (int i = 0; i < 4; i++) laneBits[i*8 +: 8] = {8{sel[i]}};
  endfunction

  // processor model: present a request, hold it until ready
  task automatic doAccess(input bit r, input logic [31:0] ra, input logic [1:0] rs,
                          input bit w, input logic [31:0] wa, input logic [1:0] ws,
                          input logic [31:0] wd, input int lat,
                          output int cycles, output logic [31:0] rdat, output int firstTxn);
    slvLat = lat;
    @(negedge clk);
    firstTxn = txnCount;
    rdEn = r; rdAddr = ra; rdSize = rs;
    wrEn = w; wrAddr = wa; wrSize = ws; wrData = wd;
    cycles = 0;
    rdat = '0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      cycles++;
      if (coreReady) begin
        rdat = coreRdData;
        break;
      end
    end
    rdEn = 1'b0;
    wrEn = 1'b0;
    @(negedge clk);
    check(!wbCyc && !wbStb, "R9 cycle dropped after final ack", {31'd0, wbCyc}, 32'd0);
  endtask

  task automatic testReset();
    check(!wbCyc && !wbStb && !wbWe, "R1 bus quiet after reset",
          {29'd0, wbCyc, wbStb, wbWe}, 32'd0);
    check(coreReady, "R1 ready while idle", {31'd0, coreReady}, 32'd1);
  endtask

  task automatic testRead(input logic [31:0] a, input logic [1:0] sz, input int lat,
                          input logic [3:0] expSel, input logic [31:0] expData);
    int cyc, t0;
    logic [31:0] d;
    doAccess(1'b1, a, sz, 1'b0, '0, 2'b00, '0, lat, cyc, d, t0);
    check(txnCount == t0 + 1, "R2 one load transaction", txnCount - t0, 1);
    check(txnWe[t0 % 8] == 1'b0, "R2 load has write flag low", {31'd0, txnWe[t0 % 8]}, 32'd0);
    check(txnAdr[t0 % 8] == a[31:2], "R4 load word address", {2'b0, txnAdr[t0 % 8]}, {2'b0, a[31:2]});
    check(txnSel[t0 % 8] == expSel, "R5 load lane select", {28'd0, txnSel[t0 % 8]}, {28'd0, expSel});
    check(cyc == 2 + lat, "R6 load ready timing", cyc, 2 + lat);
    check(d == expData, "R7 load data justified", d, expData);
  endtask

  task automatic testWrite(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd,
                           input int lat, input logic [3:0] expSel, input logic [31:0] expLanes);
    int cyc, t0;
    logic [31:0] d;
    doAccess(1'b0, '0, 2'b00, 1'b1, a, sz, wd, lat, cyc, d, t0);
    check(txnCount == t0 + 1, "R3 one store transaction", txnCount - t0, 1);
    check(txnWe[t0 % 8] == 1'b1, "R3 store has write flag high", {31'd0, txnWe[t0 % 8]}, 32'd1);
    check(txnAdr[t0 % 8] == a[31:2], "R4 store word address", {2'b0, txnAdr[t0 % 8]}, {2'b0, a[31:2]});
    check(txnSel[t0 % 8] == expSel, "R5 store lane select", {28'd0, txnSel[t0 % 8]}, {28'd0, expSel});
    check((txnDat[t0 % 8] & laneBits(expSel)) == expLanes, "R3 store data steered",
          txnDat[t0 % 8] & laneBits(expSel), expLanes);
    check(cyc == 2 + lat, "R6 store ready timing", cyc, 2 + lat);
  endtask

  task automatic testBoth(input int lat);
    int cyc, t0;
    logic [31:0] d;
    doAccess(1'b1, 32'h0000_0021, 2'b00, 1'b1, 32'h0000_0010, 2'b10, 32'h5566_7788,
             lat, cyc, d, t0);
    check(txnCount == t0 + 2, "R8 two transactions", txnCount - t0, 2);
    check(txnWe[t0 % 8] == 1'b1, "R8 store runs first", {31'd0, txnWe[t0 % 8]}, 32'd1);
    check(txnAdr[t0 % 8] == 30'h4, "R8 store address", {2'b0, txnAdr[t0 % 8]}, 32'h4);
    check(txnDat[t0 % 8] == 32'h5566_7788, "R8 store data", txnDat[t0 % 8], 32'h5566_7788);
    check(txnWe[(t0 + 1) % 8] == 1'b0, "R8 load runs second", {31'd0, txnWe[(t0 + 1) % 8]}, 32'd0);
    check(txnAdr[(t0 + 1) % 8] == 30'h8, "R8 load address", {2'b0, txnAdr[(t0 + 1) % 8]}, 32'h8);
    check(txnSel[(t0 + 1) % 8] == 4'b0010, "R8 load select", {28'd0, txnSel[(t0 + 1) % 8]}, 32'h2);
    check(cyc == 4 + 2 * lat, "R8 ready only after load ack", cyc, 4 + 2 * lat);
    check(d == 32'h0000_00C3, "R8 load data with ready", d, 32'h0000_00C3);
  endtask

  initial begin
    rstN = 1'b0;
    rdEn = 1'b0; wrEn = 1'b0;
    rdAddr = '0; wrAddr = '0; wrData = '0; rdSize = '0; wrSize = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRead(32'h1000_0006, 2'b00, 0, 4'b0100, 32'h0000_00B2);
    testRead(32'h2000_0002, 2'b01, 2, 4'b1100, 32'h0000_A1B2);
    testRead(32'h2000_0001, 2'b01, 1, 4'b0011, 32'h0000_C3D4);
    testRead(32'h3000_0000, 2'b10, 1, 4'b1111, 32'hA1B2_C3D4);
    testWrite(32'h8000_0047, 2'b00, 32'hFFFF_FF5A, 1, 4'b1000, 32'h5A00_0000);
    testWrite(32'h0000_0101, 2'b01, 32'hAAAA_1234, 0, 4'b0011, 32'h0000_1234);
    testWrite(32'h0000_0203, 2'b01, 32'hAAAA_1234, 3, 4'b1100, 32'h1234_0000);
    testWrite(32'h0000_0302, 2'b11, 32'hCAFE_F00D, 0, 4'b1111, 32'hCAFE_F00D);
    testBoth(1);
    testBoth(0);
    @(negedge clk);
    testReset();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule